// File: doc/BRIEF.md
# Parallel Display Bus Timing Controller

This block runs single transfers on an 8080-style parallel display bus for a host. The host presents one request at a time. Each request is a write to the command port, a write to the data port, or a single read. The block then produces the active-low chip select, write strobe and read strobe, the register-select line and a 9-bit data bus with an output enable. Each bus phase lasts the number of clock cycles set in its own configuration field: setup, strobe, hold, read latency and the gap between writes. Some of these fields count cycles directly and some hold the cycle count minus one.

The controller stores the configuration and the request at the moment it accepts the request, so the host may change the configuration fields once `busy_o` has dropped. Reads return the sampled bus value on `rdata_o` together with a one-cycle `done_o` pulse. Writes also pulse `done_o` when they complete. When the write-to-write gap is zero, a write that is waiting is accepted in the last hold cycle of the write before it, and chip select stays low across both. A separate host input drives the active-low panel reset pin through a register.

Top module: `pbus_timing_ctrl`

## Requirements
- R1: While `rst_ni` is low, `lcd_cs_no`, `lcd_wr_no` and `lcd_rd_no` are high, and `lcd_d_oe_o`, `busy_o`, `done_o` and `lcd_rst_no` are low.
- R2: `lcd_rs_o` is 0 for the whole of a transfer requested with `req_data_i`=0 (command port) and 1 for one requested with `req_data_i`=1 (data port).
- R3: A write (`req_read_i`=0) holds chip select low with both strobes high for `cfg_wr_setup_i` cycles. It then holds the write strobe low for `cfg_wr_cyc_m1_i`+1 cycles, and then holds chip select low with the strobes high for `cfg_wr_hold_m1_i`+1 cycles. The write strobe is low only while chip select is low.
- R4: When `cfg_wr_setup_i` is 0, the write strobe falls in the same cycle as chip select.
- R5: A read (`req_read_i`=1) holds the read strobe low for the effective latency and samples `lcd_d_i` in the last strobe cycle. `done_o` is high for exactly one cycle, the cycle after the last hold cycle, and `rdata_o` holds the sampled value during that cycle. The read and write strobes are never low together.
- R6: The effective read latency is `cfg_rd_lat_i` clamped to the range 1 to 63 cycles. A request of 200 gives 63 and a request of 0 gives 1.
- R7: A read holds chip select low with both strobes high for `cfg_rd_setup_i` cycles before the strobe and for `cfg_rd_hold_i` cycles after it. Either count may be 0.
- R8: When the host keeps `req_i` high, the number of cycles chip select stays high between two writes is 0 if `cfg_w2w_gap_i`=0, and `cfg_w2w_gap_i`+1 otherwise.
- R9: A request is accepted only in a cycle where `busy_o` is low. A `req_i` pulse while `busy_o` is high produces no bus transfer.
- R10: With `cfg_bus9_i`=1 all 9 data bits are used. With `cfg_bus9_i`=0, bit 8 is driven as 0 on writes and returned as 0 on reads.
- R11: `lcd_rst_no` equals the inverse of `panel_rst_i` from the previous clock cycle.
- R12: `lcd_d_oe_o` is high only during the write strobe and write hold phases. It is never high during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_data_i | input | 1 | 1 = data port, 0 = command port |
| wdata_i | input | 9 | Write value |
| busy_o | output | 1 | High while a request cannot be accepted |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 9 | Last read value |
| cfg_wr_setup_i | input | 6 | Write setup cycles |
| cfg_wr_cyc_m1_i | input | 6 | Write strobe cycles minus one |
| cfg_wr_hold_m1_i | input | 6 | Write hold cycles minus one |
| cfg_w2w_gap_i | input | 6 | Extra idle cycles after a write |
| cfg_rd_setup_i | input | 6 | Read setup cycles |
| cfg_rd_lat_i | input | 8 | Requested read latency, clamped to 1..63 |
| cfg_rd_hold_i | input | 6 | Read hold cycles |
| cfg_bus9_i | input | 1 | 1 = 9-bit bus, 0 = 8-bit bus |
| panel_rst_i | input | 1 | Panel reset request, active high |
| lcd_cs_no | output | 1 | Chip select, active low |
| lcd_wr_no | output | 1 | Write strobe, active low |
| lcd_rd_no | output | 1 | Read strobe, active low |
| lcd_rs_o | output | 1 | Register select: 0 command, 1 data |
| lcd_d_o | output | 9 | Bus data out |
| lcd_d_oe_o | output | 1 | Bus output enable |
| lcd_d_i | input | 9 | Bus data in |
| lcd_rst_no | output | 1 | Panel reset, active low |

## Verification
The assertions assume that the host changes `req_read_i`, `req_data_i` and `wdata_i` only while no request is being accepted. They also assume that `panel_rst_i` is a synchronous level. The bench changes request fields and configuration only at falling clock edges, and it changes configuration only while the controller is idle. It also holds `lcd_d_i` steady for the whole of each read. Under these conditions the register-select and strobe checks describe the bus the controller produces, not glitches in the host's own stimulus.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int DATA_W    = 9;
  localparam int FLD_W     = 6;
  localparam int LAT_REQ_W = 8;
  localparam int LAT_MAX   = (1 << FLD_W) - 1;

  typedef logic [FLD_W-1:0]  fld_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WSU, PH_WSTB, PH_WHLD, PH_GAP, PH_RSU, PH_RSTB, PH_RHLD
  } phase_e;

  typedef struct packed {
    fld_t wr_setup;
    fld_t wr_cyc_m1;
    fld_t wr_hold_m1;
    fld_t w2w_gap;
    fld_t rd_setup;
    fld_t rd_lat;
    fld_t rd_hold;
    logic bus9;
  } cfg_t;

  typedef struct packed {
    logic  is_read;
    logic  is_data;
    data_t wdata;
  } txn_t;

  function automatic fld_t clamp_lat(input logic [LAT_REQ_W-1:0] req);
    if (int'(req) > LAT_MAX) return fld_t'(LAT_MAX);
    if (req == '0) return fld_t'(1);
    return fld_t'(req);
  endfunction

  function automatic data_t narrow(input data_t d, input logic bus9);
    data_t m;
    m = d;
    if (!bus9) m[DATA_W-1] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/pbus_phase_cnt.sv
module pbus_phase_cnt #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   req_read_i,
  input  logic   req_data_i,
  input  data_t  wdata_i,
  input  cfg_t   cfg_i,
  input  logic   last_i,
  output phase_e state_o,
  output logic   load_o,
  output fld_t   load_val_o,
  output cfg_t   cfg_q_o,
  output txn_t   txn_q_o,
  output logic   ready_o
);
  phase_e state_q, nxt;
  cfg_t   cfg_q, act_cfg;
  txn_t   txn_q;
  logic   accept;

  function automatic phase_e first_ph(input cfg_t c, input logic rd);
    if (rd) return (c.rd_setup != '0) ? PH_RSU : PH_RSTB;
    return (c.wr_setup != '0) ? PH_WSU : PH_WSTB;
  endfunction

  function automatic phase_e succ(input phase_e p, input cfg_t c);
    case (p)
      PH_WSU:  return PH_WSTB;
      PH_WSTB: return PH_WHLD;
      PH_WHLD: return (c.w2w_gap != '0) ? PH_GAP : PH_IDLE;
      PH_RSU:  return PH_RSTB;
      PH_RSTB: return (c.rd_hold != '0) ? PH_RHLD : PH_IDLE;
      default: return PH_IDLE;
    endcase
  endfunction

  // counter preload = phase length - 1
  function automatic fld_t len_m1(input phase_e p, input cfg_t c);
    case (p)
      PH_WSU:  return c.wr_setup - 1'b1;
      PH_WSTB: return c.wr_cyc_m1;
      PH_WHLD: return c.wr_hold_m1;
      PH_GAP:  return c.w2w_gap - 1'b1;
      PH_RSU:  return c.rd_setup - 1'b1;
      PH_RSTB: return c.rd_lat - 1'b1;
      PH_RHLD: return c.rd_hold - 1'b1;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    // zero gap: take the next write in the last hold cycle
    ready_o = (state_q == PH_IDLE) ||
              (state_q == PH_WHLD && last_i && cfg_q.w2w_gap == '0);
    accept  = req_i && ready_o;
    act_cfg = accept ? cfg_i : cfg_q;
    nxt     = state_q;
    if (accept)                            nxt = first_ph(cfg_i, req_read_i);
    else if (state_q != PH_IDLE && last_i) nxt = succ(state_q, cfg_q);
    load_o     = (nxt != state_q) && (nxt != PH_IDLE);
    load_val_o = len_m1(nxt, act_cfg);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cfg_q   <= '0;
      txn_q   <= '0;
    end else begin
      state_q <= nxt;
      if (accept) begin
        cfg_q <= cfg_i;
        txn_q <= '{is_read: req_read_i, is_data: req_data_i, wdata: wdata_i};
      end
    end
  end

  assign state_o = state_q;
  assign cfg_q_o = cfg_q;
  assign txn_q_o = txn_q;
endmodule

// File: rtl/pbus_pins.sv
module pbus_pins
  import pbus_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e state_i,
  input  logic   last_i,
  input  logic   rd_hold_zero_i,
  input  logic   bus9_i,
  input  logic   is_data_i,
  input  data_t  wdata_i,
  input  data_t  lcd_d_i,
  input  logic   panel_rst_i,
  output logic   lcd_cs_no,
  output logic   lcd_wr_no,
  output logic   lcd_rd_no,
  output logic   lcd_rs_o,
  output data_t  lcd_d_o,
  output logic   lcd_d_oe_o,
  output logic   lcd_rst_no,
  output data_t  rdata_o,
  output logic   done_o
);
  logic  done_q, rst_q;
  data_t rdata_q;
  logic  fin;

  assign lcd_cs_no  = (state_i == PH_IDLE) || (state_i == PH_GAP);
  assign lcd_wr_no  = (state_i != PH_WSTB);
  assign lcd_rd_no  = (state_i != PH_RSTB);
  assign lcd_d_oe_o = (state_i == PH_WSTB) || (state_i == PH_WHLD);
  assign lcd_d_o    = lcd_d_oe_o ? narrow(wdata_i, bus9_i) : '0;
  assign lcd_rs_o   = is_data_i;

  assign fin = last_i && ((state_i == PH_WHLD) || (state_i == PH_RHLD) ||
                          (state_i == PH_RSTB && rd_hold_zero_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
      rst_q   <= 1'b0;
    end else begin
      done_q <= fin;
      rst_q  <= !panel_rst_i;
      if (state_i == PH_RSTB && last_i) rdata_q <= narrow(lcd_d_i, bus9_i);
    end
  end

  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign lcd_rst_no = rst_q;
endmodule

// File: rtl/pbus_timing_ctrl.sv
module pbus_timing_ctrl
  import pbus_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 req_read_i,
  input  logic                 req_data_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [FLD_W-1:0]     cfg_wr_setup_i,
  input  logic [FLD_W-1:0]     cfg_wr_cyc_m1_i,
  input  logic [FLD_W-1:0]     cfg_wr_hold_m1_i,
  input  logic [FLD_W-1:0]     cfg_w2w_gap_i,
  input  logic [FLD_W-1:0]     cfg_rd_setup_i,
  input  logic [LAT_REQ_W-1:0] cfg_rd_lat_i,
  input  logic [FLD_W-1:0]     cfg_rd_hold_i,
  input  logic                 cfg_bus9_i,
  input  logic                 panel_rst_i,
  output logic                 lcd_cs_no,
  output logic                 lcd_wr_no,
  output logic                 lcd_rd_no,
  output logic                 lcd_rs_o,
  output logic [DATA_W-1:0]    lcd_d_o,
  output logic                 lcd_d_oe_o,
  input  logic [DATA_W-1:0]    lcd_d_i,
  output logic                 lcd_rst_no
);
  cfg_t   cfg_in, cfg_q;
  txn_t   txn_q;
  phase_e state;
  logic   load, last, ready;
  fld_t   load_val;

  always_comb begin
    cfg_in.wr_setup   = cfg_wr_setup_i;
    cfg_in.wr_cyc_m1  = cfg_wr_cyc_m1_i;
    cfg_in.wr_hold_m1 = cfg_wr_hold_m1_i;
    cfg_in.w2w_gap    = cfg_w2w_gap_i;
    cfg_in.rd_setup   = cfg_rd_setup_i;
    cfg_in.rd_lat     = clamp_lat(cfg_rd_lat_i);
    cfg_in.rd_hold    = cfg_rd_hold_i;
    cfg_in.bus9       = cfg_bus9_i;
  end

  pbus_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .req_read_i (req_read_i),
    .req_data_i (req_data_i),
    .wdata_i    (wdata_i),
    .cfg_i      (cfg_in),
    .last_i     (last),
    .state_o    (state),
    .load_o     (load),
    .load_val_o (load_val),
    .cfg_q_o    (cfg_q),
    .txn_q_o    (txn_q),
    .ready_o    (ready)
  );

  pbus_phase_cnt #(.W(FLD_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  pbus_pins u_pins (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .state_i        (state),
    .last_i         (last),
    .rd_hold_zero_i (cfg_q.rd_hold == '0),
    .bus9_i         (cfg_q.bus9),
    .is_data_i      (txn_q.is_data),
    .wdata_i        (txn_q.wdata),
    .lcd_d_i        (lcd_d_i),
    .panel_rst_i    (panel_rst_i),
    .lcd_cs_no      (lcd_cs_no),
    .lcd_wr_no      (lcd_wr_no),
    .lcd_rd_no      (lcd_rd_no),
    .lcd_rs_o       (lcd_rs_o),
    .lcd_d_o        (lcd_d_o),
    .lcd_d_oe_o     (lcd_d_oe_o),
    .lcd_rst_no     (lcd_rst_no),
    .rdata_o        (rdata_o),
    .done_o         (done_o)
  );

  assign busy_o = !ready;
endmodule

// File: rtl/pbus_timing_ctrl_chk.sv
module pbus_timing_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic done_o,
  input logic lcd_cs_no,
  input logic lcd_wr_no,
  input logic lcd_rd_no,
  input logic lcd_rs_o,
  input logic lcd_d_oe_o,
  input logic panel_rst_i,
  input logic lcd_rst_no
);
  assert_wr_in_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lcd_wr_no |-> !lcd_cs_no);

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!lcd_wr_no && !lcd_rd_no));

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_oe_window_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_d_oe_o |-> (!lcd_cs_no && lcd_rd_no));

  // a new transfer may only change RS in the cycle done marks the boundary
  assert_rs_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lcd_cs_no && !done_o && $past(!lcd_cs_no)) |-> $stable(lcd_rs_o));

  assert_rst_on_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_rst_i |=> !lcd_rst_no);

  assert_rst_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !panel_rst_i |=> lcd_rst_no);
endmodule

bind pbus_timing_ctrl pbus_timing_ctrl_chk u_chk (.*);

// File: tb/pbus_timing_ctrl_tb.sv
module pbus_timing_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, req_read_i = 1'b0, req_data_i = 1'b0;
  logic [8:0] wdata_i = '0;
  logic       busy_o, done_o;
  logic [8:0] rdata_o;
  logic [5:0] wr_setup = 6'd3, wr_cyc_m1 = 6'd10, wr_hold_m1 = 6'd1, w2w_gap = 6'd0;
  logic [5:0] rd_setup = 6'd0, rd_hold = 6'd15;
  logic [7:0] rd_lat = 8'd5;
  logic       bus9 = 1'b1, panel_rst = 1'b0;
  logic       cs_n, wr_n, rd_n, rs, oe, rst_n;
  logic [8:0] d_o, d_i = '0;

  int checks = 0, fails = 0;
  int hi_total = 0, oe_bad = 0;

  typedef struct {
    bit    rd;
    bit    rs;
    int    pre, stb, post, val;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  pbus_timing_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_read_i(req_read_i),
    .req_data_i(req_data_i), .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o),
    .rdata_o(rdata_o), .cfg_wr_setup_i(wr_setup), .cfg_wr_cyc_m1_i(wr_cyc_m1),
    .cfg_wr_hold_m1_i(wr_hold_m1), .cfg_w2w_gap_i(w2w_gap), .cfg_rd_setup_i(rd_setup),
    .cfg_rd_lat_i(rd_lat), .cfg_rd_hold_i(rd_hold), .cfg_bus9_i(bus9),
    .panel_rst_i(panel_rst), .lcd_cs_no(cs_n), .lcd_wr_no(wr_n), .lcd_rd_no(rd_n),
    .lcd_rs_o(rs), .lcd_d_o(d_o), .lcd_d_oe_o(oe), .lcd_d_i(d_i), .lcd_rst_no(rst_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_lat(input int l);
    if (l > 63) return 63;
    if (l == 0) return 1;
    return l;
  endfunction

  // driver: present request, wait for acceptance, push expectation
  task automatic issue(input bit rd, input bit dsel, input logic [8:0] wd, input string tag);
    exp_t e;
    req_i = 1'b1; req_read_i = rd; req_data_i = dsel; wdata_i = wd;
    while (busy_o) @(negedge clk);
    e.rd = rd; e.rs = dsel; e.tag = tag;
    if (rd) begin
      e.pre = rd_setup; e.stb = eff_lat(rd_lat); e.post = rd_hold;
      e.val = bus9 ? d_i : (d_i & 9'h0FF);
    end else begin
      e.pre = wr_setup; e.stb = wr_cyc_m1 + 1; e.post = wr_hold_m1 + 1;
      e.val = bus9 ? wd : (wd & 9'h0FF);
    end
    q.push_back(e);
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: rebuild each transfer from the pins, compare at done
  initial begin
    bit m_rd = 0, m_rs = 0, m_stb_seen = 0;
    int pre = 0, stb = 0, post = 0, val = 0;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (cs_n) hi_total++;
        if (done_o) begin
          exp_t e;
          if (m_rd) val = rdata_o;
          if (q.size() == 0) begin
            chk(0, "R9 unexpected transfer", 1, 0);
          end else begin
            e = q.pop_front();
            chk(m_rd == e.rd, {e.tag, " kind"}, m_rd, e.rd);
            chk(m_rs == e.rs, {"R2 ", e.tag, " rs"}, m_rs, e.rs);
            chk(pre == e.pre, {e.tag, " setup"}, pre, e.pre);
            chk(stb == e.stb, {e.tag, " strobe"}, stb, e.stb);
            chk(post == e.post, {e.tag, " hold"}, post, e.post);
            chk(val == e.val, {e.tag, " data"}, val, e.val);
          end
          pre = 0; stb = 0; post = 0; m_stb_seen = 0;
        end
        if (!cs_n) begin
          if (!wr_n || !rd_n) begin
            if (!m_stb_seen) begin
              m_rd = !rd_n; m_rs = rs; val = d_o;
            end
            m_stb_seen = 1; stb++;
            if (!wr_n && !oe) oe_bad++;
            if (!rd_n && oe) oe_bad++;
          end else if (!m_stb_seen) begin
            pre++;
            if (oe) oe_bad++;
          end else begin
            post++;
            if (oe == m_rd) oe_bad++;
          end
        end else if (oe) oe_bad++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n && wr_n && rd_n, "R1 strobes high in reset", {cs_n, wr_n, rd_n}, 7);
    chk(!oe && !busy_o && !done_o, "R1 oe/busy/done low", {oe, busy_o, done_o}, 0);
    chk(!rst_n, "R1 panel reset low", rst_n, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R11 panel reset follows input one cycle later
    chk(rst_n, "R11 panel reset released", rst_n, 1);
    panel_rst = 1'b1; @(negedge clk);
    chk(!rst_n, "R11 panel reset asserted", rst_n, 0);
    panel_rst = 1'b0; @(negedge clk);
    chk(rst_n, "R11 panel reset deasserted", rst_n, 1);

    // R3 command write with typical timing, R9 busy and ignored pulse
    issue(0, 0, 9'h02C, "R3 cmd write");
    chk(busy_o, "R9 busy during transfer", busy_o, 1);
    req_i = 1'b1; req_read_i = 1'b1; @(negedge clk); req_i = 1'b0;
    wait_idle();

    // R2 R10 data write with 9-bit value
    issue(0, 1, 9'h1A5, "R10 data write 9b");
    wait_idle();

    // R4 zero setup
    wr_setup = 6'd0; wr_cyc_m1 = 6'd0; wr_hold_m1 = 6'd0;
    issue(0, 1, 9'h0F0, "R4 zero setup write");
    wait_idle();
    wr_setup = 6'd3; wr_cyc_m1 = 6'd10; wr_hold_m1 = 6'd1;

    // R5 R7 read, setup 0, hold 15
    d_i = 9'h15A;
    issue(1, 1, 9'h000, "R5 read lat5");
    wait_idle();

    // R6 clamping
    rd_lat = 8'd200; d_i = 9'h0C3;
    issue(1, 0, 9'h000, "R6 read lat clamp 63");
    wait_idle();
    rd_lat = 8'd0; d_i = 9'h101;
    issue(1, 1, 9'h000, "R6 read lat zero");
    wait_idle();

    // R7 read setup 2, hold 0
    rd_lat = 8'd3; rd_setup = 6'd2; rd_hold = 6'd0; d_i = 9'h077;
    issue(1, 1, 9'h000, "R7 read setup2 hold0");
    wait_idle();
    rd_setup = 6'd0; rd_hold = 6'd15;

    // R10 8-bit mode write and read
    bus9 = 1'b0;
    issue(0, 1, 9'h1A5, "R10 write 8b");
    wait_idle();
    d_i = 9'h1FF;
    issue(1, 1, 9'h000, "R10 read 8b");
    wait_idle();
    bus9 = 1'b1;

    // R8 zero gap: no chip-select high cycle between writes
    w2w_gap = 6'd0;
    issue(0, 0, 9'h02A, "R8 b2b first");
    h0 = hi_total;
    issue(0, 1, 9'h011, "R8 b2b second");
    chk(hi_total - h0 == 0, "R8 gap0 cs high cycles", hi_total - h0, 0);
    wait_idle();

    // R8 gap 3: four high cycles
    w2w_gap = 6'd3;
    issue(0, 0, 9'h02B, "R8 gap3 first");
    h0 = hi_total;
    issue(0, 1, 9'h03F, "R8 gap3 second");
    chk(hi_total - h0 == 4, "R8 gap3 cs high cycles", hi_total - h0, 4);
    wait_idle();
    w2w_gap = 6'd0;

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R9 all expected transfers seen", q.size(), 0);
    chk(oe_bad == 0, "R12 output enable window", oe_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule